// File: doc/BRIEF.md
# Event-Qualified 16-bit Counter

This block is a 16-bit up-counter. Its count enable comes from one of two places. The first is a one-cycle tick from an internal divider; the divider itself is not part of this block. The second is an asynchronous event pin. A 4-bit source-select field chooses between them. One code of that field routes the event pin to the counter, and every other code uses the internal tick. No separate mode bit exists.

The event pin first passes through a two-flop synchronizer. It then passes through a width qualifier, which accepts a new level only after that level has been sampled on three consecutive clocks. Any return to the old level before then discards the attempt. An accepted level change makes a one-cycle rising or falling pulse.

A 2-bit edge mode picks which pulses count:
- rising edges only
- falling edges only
- both edges
- none

The counter wraps at all-ones and gives a one-cycle wrap pulse. A run input gates counting. A synchronous clear zeroes the counter and resynchronizes the qualifier.

Top module: `evt_counter`

## Requirements
- R1: After reset, `count_o` is 0 and `wrap_o` is 0.
- R2: When `src_sel_i` equals 4'b0111, the counter advances by exactly 1 for each qualified event edge that the edge mode selects, and `tick_i` has no effect.
- R3: When `src_sel_i` is any other value (for example 4'b1111), the counter advances by 1 on each clock where `tick_i` is high, and the event pin has no effect.
- R4: A new event level is accepted only after it has been sampled on 3 consecutive clocks after synchronization. A pulse that lasts 1 or 2 clocks is never counted; a pulse that lasts 3 clocks is counted.
- R5: The edge mode encoding is 2'b00 = rising edges, 2'b01 = falling edges, 2'b10 = both edges, 2'b11 = counting disabled.
- R6: A qualifying event change that is first sampled at rising clock edge 1 updates `count_o` at rising edge 6: two synchronizer stages, three qualifying samples, then one counter register.
- R7: In both-edge mode, an event that toggles every 3 clocks (period of 6 clocks) counts every edge.
- R8: The count wraps from 16'hFFFF to 16'h0000. `wrap_o` is high for exactly the one cycle after the wrap and low otherwise.
- R9: `clear_i` sets the count to 0 on the next edge, taking priority over an increment in the same cycle. It also discards a partially qualified event level, so that level produces no edge.
- R10: While `run_i` is low, `count_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_async_i | input | 1 | Asynchronous external event pin |
| src_sel_i | input | 4 | Count source select; 4'b0111 selects the event pin |
| edge_mode_i | input | 2 | Edge mode: 00 rise, 01 fall, 10 both, 11 off |
| run_i | input | 1 | Counting allowed while high |
| clear_i | input | 1 | Synchronous clear of count and qualifier |
| tick_i | input | 1 | One-cycle internal count tick |
| count_o | output | 16 | Current count |
| wrap_o | output | 1 | One-cycle pulse after a wrap to zero |

## Verification
A qualifier whose run length is off by one shows at the ports within six clocks. It either counts 2-clock glitches or misses 3-clock pulses, and the count then differs after each settled segment. A wrong edge-mode decode or source mux makes the count drift away from the edge totals the bench predicts. The latency check samples the exact edge on which the count should move, so any extra or missing pipeline stage shows up one clock early or one clock late. Wrap and clear faults appear on the first clock after the event that triggers them.

// File: rtl/evc_pkg.sv
package evc_pkg;

  typedef enum logic [1:0] {
    EDGE_RISE = 2'b00,
    EDGE_FALL = 2'b01,
    EDGE_BOTH = 2'b10,
    EDGE_OFF  = 2'b11
  } edge_mode_e;

  // Decide whether a qualified edge pulse counts under the given mode.
  function automatic logic edge_hit(edge_mode_e mode, logic rise, logic fall);
    case (mode)
      EDGE_RISE: return rise;
      EDGE_FALL: return fall;
      EDGE_BOTH: return rise | fall;
      default:   return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/evc_sync.sv
module evc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= d_i;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain_q[i] <= 1'b0;
          else        chain_q[i] <= chain_q[i-1];
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/evc_qualifier.sv
module evc_qualifier #(
  parameter int QUAL = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic lvl_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int RW = $clog2(QUAL + 1);
  localparam logic [RW-1:0] LAST = RW'(QUAL - 1);

  logic [RW-1:0] run_q;
  logic          level_q, rise_q, fall_q;
  logic          differs, accept;

  assign differs = (lvl_i != level_q);
  assign accept  = differs && (run_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= 1'b0;
      run_q   <= '0;
      rise_q  <= 1'b0;
      fall_q  <= 1'b0;
    end else if (clr_i) begin
      level_q <= lvl_i;
      run_q   <= '0;
      rise_q  <= 1'b0;
      fall_q  <= 1'b0;
    end else begin
      rise_q <= accept && lvl_i;
      fall_q <= accept && !lvl_i;
      if (!differs)     run_q <= '0;
      else if (accept) begin
        level_q <= lvl_i;
        run_q   <= '0;
      end else          run_q <= run_q + 1'b1;
    end
  end

  assign level_o = level_q;
  assign rise_o  = rise_q;
  assign fall_o  = fall_q;

  // R4: an accepted level was seen on the input for the full run
  a_r4_full_run: assert property (@(posedge clk) disable iff (!rst_n)
    (level_q != $past(level_q)) && !$past(clr_i)
      |-> ($past(run_q) == LAST) && ($past(lvl_i) == level_q));
  // R5: rise and fall pulses are never simultaneous
  a_r5_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rise_q, fall_q}));
  // R4: a pulse lasts one cycle only
  a_r4_pulse_short: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_q || fall_q) |=> !(rise_q || fall_q));
endmodule

// File: rtl/evc_counter.sv
module evc_counter #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [WIDTH-1:0] count_o,
  output logic             wrap_o
);
  localparam logic [WIDTH-1:0] TOP = '1;

  logic [WIDTH-1:0] count_q;
  logic             wrap_q;

  function automatic logic [WIDTH-1:0] step(logic [WIDTH-1:0] v);
    return v + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      wrap_q  <= 1'b0;
    end else if (clr_i) begin
      count_q <= '0;
      wrap_q  <= 1'b0;
    end else if (inc_i) begin
      count_q <= step(count_q);
      wrap_q  <= (count_q == TOP);
    end else begin
      wrap_q  <= 1'b0;
    end
  end

  assign count_o = count_q;
  assign wrap_o  = wrap_q;

  // R2: an increment advances by exactly one
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !clr_i) |=> (count_q == $past(count_q) + 1'b1));
  // R10: no increment, no change
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc_i && !clr_i) |=> $stable(count_q));
  // R9: clear wins and zeroes
  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (count_q == '0) && !wrap_q);
  // R8: wrap pulse only with a zero count, one cycle long
  a_r8_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_q |-> (count_q == '0) && ($past(count_q) == TOP));
  a_r8_wrap_once: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_q |=> !wrap_q);
endmodule

// File: rtl/evt_counter.sv
module evt_counter
  import evc_pkg::*;
#(
  parameter int          WIDTH       = 16,
  parameter int          SYNC_STAGES = 2,
  parameter int          QUAL_CYCLES = 3,
  parameter int          SEL_W       = 4,
  parameter logic [3:0]  EXT_SEL     = 4'b0111
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_async_i,
  input  logic [SEL_W-1:0] src_sel_i,
  input  logic [1:0]       edge_mode_i,
  input  logic             run_i,
  input  logic             clear_i,
  input  logic             tick_i,
  output logic [WIDTH-1:0] count_o,
  output logic             wrap_o
);
  localparam logic [SEL_W-1:0] EXT_CODE = SEL_W'(EXT_SEL);

  logic       evt_sync, evt_level, evt_rise, evt_fall;
  logic       use_ext, evt_hit, count_en;
  edge_mode_e mode;

  assign mode    = edge_mode_e'(edge_mode_i);
  assign use_ext = (src_sel_i == EXT_CODE);

  evc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(evt_async_i), .q_o(evt_sync)
  );

  evc_qualifier #(.QUAL(QUAL_CYCLES)) u_qual (
    .clk(clk), .rst_n(rst_n), .clr_i(clear_i), .lvl_i(evt_sync),
    .level_o(evt_level), .rise_o(evt_rise), .fall_o(evt_fall)
  );

  assign evt_hit  = edge_hit(mode, evt_rise, evt_fall);
  assign count_en = run_i && (use_ext ? evt_hit : tick_i);

  evc_counter #(.WIDTH(WIDTH)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr_i(clear_i), .inc_i(count_en),
    .count_o(count_o), .wrap_o(wrap_o)
  );

  // R3: with an internal source and no tick, the event pin cannot move the count
  a_r3_evt_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!use_ext && !tick_i && !clear_i) |=> $stable(count_o));
  // R2: with the external source, a tick alone cannot move the count
  a_r2_tick_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (use_ext && !evt_rise && !evt_fall && !clear_i) |=> $stable(count_o));
  // R5: disabled edge mode freezes the external count
  a_r5_mode_off: assert property (@(posedge clk) disable iff (!rst_n)
    (use_ext && mode == EDGE_OFF && !clear_i) |=> $stable(count_o));
  // R10: run low holds the count
  a_r10_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !clear_i) |=> $stable(count_o));
  // R4: qualified level follows the synchronized input only after it settles
  a_r4_level_src: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt_level) && !$past(clear_i) |-> $past(evt_sync));
endmodule

// File: tb/evt_counter_bench.sv
`timescale 1ns/1ps
module evt_counter_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        evt = 1'b0;
  logic [3:0]  sel = 4'b0111;
  logic [1:0]  mode = 2'b00;
  logic        run = 1'b0;
  logic        clr = 1'b0;
  logic        tick = 1'b0;
  logic [15:0] count;
  logic        wrap;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic lvl = 1'b0;
  int model = 0;

  always #2.5 clk = ~clk;

  evt_counter u_evt_counter (
    .clk(clk), .rst_n(rst_n), .evt_async_i(evt), .src_sel_i(sel),
    .edge_mode_i(mode), .run_i(run), .clear_i(clr), .tick_i(tick),
    .count_o(count), .wrap_o(wrap)
  );

  // Edges counted per direction under each mode encoding
  function automatic int edge_counts(logic [1:0] m, logic rising);
    case (m)
      2'b00:   return rising ? 1 : 0;
      2'b01:   return rising ? 0 : 1;
      2'b10:   return 1;
      default: return 0;
    endcase
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_evt(logic v, int hold);
    evt = v;
    cyc(hold);
  endtask

  task automatic ticks(int n);
    tick = 1'b1;
    cyc(n);
    tick = 1'b0;
  endtask

  task automatic pulse_clear();
    clr = 1'b1;
    cyc(1);
    clr = 1'b0;
  endtask

  initial begin
    cyc(150000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    cyc(4);
    rst_n = 1'b1;
    cyc(1);
    check("R1 count after reset", count, 0);
    check("R1 wrap after reset", wrap, 0);

    // R6 latency with R2 rising edge
    run = 1'b1; sel = 4'b0111; mode = 2'b00;
    evt = 1'b1;
    cyc(5);
    check("R6 count before 6th edge", count, 0);
    cyc(1);
    check("R6 count at 6th edge", count, 1);
    cyc(3);
    set_evt(1'b0, 8);
    check("R5 rising mode ignores fall", count, 1);

    ticks(5);
    check("R2 tick ignored on external source", count, 1);

    // R4 glitch filtering
    set_evt(1'b1, 2); set_evt(1'b0, 8);
    check("R4 two-clock pulse not counted", count, 1);
    set_evt(1'b1, 3); set_evt(1'b0, 8);
    check("R4 three-clock pulse counted", count, 2);

    mode = 2'b01;
    set_evt(1'b1, 4); set_evt(1'b0, 8);
    check("R5 falling mode", count, 3);
    mode = 2'b11;
    set_evt(1'b1, 4); set_evt(1'b0, 8);
    check("R5 disabled mode", count, 3);

    // R7 both edges at period 6
    mode = 2'b10;
    for (int i = 0; i < 10; i++) set_evt(~evt, 3);
    cyc(8);
    check("R7 both edges at fCLK/6", count, 13);

    // R3 internal source
    sel = 4'b1111;
    set_evt(1'b1, 4); set_evt(1'b0, 8);
    check("R3 event ignored on internal source", count, 13);
    ticks(7);
    cyc(1);
    check("R3 ticks counted", count, 20);

    // R10 run low
    run = 1'b0;
    ticks(5);
    sel = 4'b0111;
    set_evt(1'b1, 4); set_evt(1'b0, 8);
    check("R10 run low holds", count, 20);
    run = 1'b1;

    // R9 clear priority and partial qualification
    sel = 4'b1111;
    tick = 1'b1; clr = 1'b1;
    cyc(1);
    tick = 1'b0; clr = 1'b0;
    cyc(1);
    check("R9 clear beats tick", count, 0);
    sel = 4'b0111; mode = 2'b00;
    evt = 1'b1;
    cyc(3);
    pulse_clear();
    cyc(8);
    check("R9 partial level discarded", count, 0);
    set_evt(1'b0, 8);
    set_evt(1'b1, 8);
    check("R9 counting resumes after clear", count, 1);
    set_evt(1'b0, 8);

    // R8 wrap
    pulse_clear();
    sel = 4'b1111;
    ticks(65535);
    check("R8 count at all-ones", count, 65535);
    check("R8 no wrap before top", wrap, 0);
    ticks(1);
    check("R8 count after wrap", count, 0);
    check("R8 wrap pulse", wrap, 1);
    cyc(1);
    check("R8 wrap one cycle", wrap, 0);

    // Random segments on the external source: R2 R4 R5 R7
    sel = 4'b0111;
    pulse_clear();
    model = 0;
    lvl = 1'b0;
    for (int r = 0; r < 40; r++) begin
      mode = 2'($urandom % 4);
      for (int s = 0; s < 10; s++) begin
        if (($urandom % 3) == 0) begin
          set_evt(~lvl, 1 + int'($urandom % 2));
          set_evt(lvl, 3);
        end else begin
          lvl = ~lvl;
          model += edge_counts(mode, lvl);
          set_evt(lvl, 3 + int'($urandom % 4));
        end
      end
      cyc(8);
      check("R2 R4 R5 random segment", count, model);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule